// File: doc/BRIEF.md
# Predicated Scalar Masked Fill Unit

This block walks a destination stream in step with an integer predicate stream, where each destination element has exactly one predicate element. Each element whose predicate selects it is replaced by a single fill value. Every other element passes through with its old contents, so the destination is a read-modify-write merge and is never zeroed. The default polarity fills where the predicate is zero. One command bit reverses this so that the fill lands where the predicate is nonzero. A typical use is to poke a constant such as negative infinity into the masked-off part of a score tile.

A command is accepted with a valid/ready handshake while the unit is idle. It carries the polarity, the predicate element type, the input and output data types, the source of the fill value, a 32-bit inline immediate, the active lane count and the element count. The command is checked when it is accepted. An illegal command raises a one-cycle error pulse and is discarded, and no stream element is taken for it. A legal command takes exactly its element count of elements and then returns to idle.

The predicate input and the old-destination input are consumed together. Both ready signals are high only in a cycle where both valids are high, the unit is busy, and the single output register is empty or being drained. When the consumer holds dst_out_ready low, the output register keeps its data and input acceptance pauses. Full throughput is one element per cycle. The fill value comes from the inline immediate or from a lookup port that answers in the same cycle: either per lane, or from a fixed entry chosen by the immediate.

Top module: `pmask_fill`

## Requirements
- R1: With polarity 0, an element whose predicate is nonzero leaves the output equal to its old destination value, and an element whose predicate is zero receives the fill value.
- R2: With polarity 1, an element whose predicate is nonzero receives the fill value, and an element whose predicate is zero keeps its old destination value.
- R3: Predicate type codes are 1=u8, 2=s8, 3=u16, 4=s16, 5=u32, 6=s32. An element is true when its low 8, 16 or 32 bits (per that code) are nonzero. Bits above that width are ignored, and the sign plays no part.
- R4: A command is illegal and is dropped if any of these holds: polarity above 1; predicate type outside 1..6; data type outside 1..10; input type differing from output type; fill mode 3; lane count 0 or above 128; element count 0. For a dropped command, cmd_error is high for exactly the one cycle after acceptance, and no predicate or destination element is consumed.
- R5: Data type codes 1, 2 and 10 are 8 bits wide; 3, 4, 7 and 8 are 16 bits; 5, 6 and 9 are 32 bits. A filled element takes only the low data-width bits of the fill value, bit-exact. The upper bits come from the old destination value.
- R6: In fill mode 1, the element with index e in the command uses the lookup entry at lane e mod the lane count. The unit presents that lane on fill_idx.
- R7: In fill mode 2, every element uses the lookup entry whose index is the low 7 bits of the immediate. In mode 0, the immediate itself is used.
- R8: Outputs leave in input order, at one element per cycle when there is no stall. While dst_out_valid is high and dst_out_ready is low, the output keeps its valid and data.
- R9: cmd_ready is low from the cycle after a legal command is accepted until its last element has been accepted, and then returns high.
- R10: After reset, cmd_ready is 1, dst_out_valid is 0 and cmd_error is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Unit idle; command taken when both high |
| cmd_polarity | input | 8 | 0 fills on false predicate, 1 fills on true |
| cmd_pred_type | input | 4 | Predicate element type code |
| cmd_in_type | input | 4 | Fill value type code |
| cmd_out_type | input | 4 | Destination type code |
| cmd_imm_mode | input | 2 | 0 inline, 1 per-lane lookup, 2 fixed lookup entry |
| cmd_imm | input | 32 | Inline immediate, or lookup index in mode 2 |
| cmd_lanes | input | 8 | Active lane count, 1..128 |
| cmd_count | input | 16 | Elements in the command |
| cmd_error | output | 1 | One-cycle pulse for a dropped command |
| pred_valid | input | 1 | Predicate element offered |
| pred_ready | output | 1 | Predicate element taken |
| pred_data | input | 32 | Predicate element, low-justified |
| dst_in_valid | input | 1 | Old destination element offered |
| dst_in_ready | output | 1 | Old destination element taken |
| dst_in_data | input | 32 | Old destination element |
| dst_out_valid | output | 1 | Merged element available |
| dst_out_ready | input | 1 | Consumer takes the merged element |
| dst_out_data | output | 32 | Merged element |
| fill_idx | output | 7 | Lookup index for the fill table |
| fill_data | input | 32 | Lookup result, same cycle |

## Verification
Two functions can land in the same cycle. One is the last element of a command sitting in the output register under back-pressure. The other is the next command being accepted and starting to take its own elements. The bench provokes this by running a per-lane lookup command while dst_out_ready stalls every third cycle. It then issues a fixed-entry command as soon as cmd_ready rises, with the stall still in effect. The outcome is judged from the full output sequence across the command boundary: each value must come from the right command's fill source and polarity, no element may be lost or duplicated, and every stalled output must keep its data.

// File: rtl/pmask_fill_pkg.sv
package pmask_fill_pkg;

  typedef enum logic [1:0] {
    FILL_INLINE = 2'd0,
    FILL_LANE   = 2'd1,
    FILL_FIXED  = 2'd2,
    FILL_BAD    = 2'd3
  } fill_mode_e;

  // element width selector: 8, 16 or 32 bits
  typedef enum logic [1:0] {
    EW_8  = 2'd0,
    EW_16 = 2'd1,
    EW_32 = 2'd2
  } ew_e;

  function automatic logic pred_code_ok(input logic [3:0] code);
    return (code >= 4'd1) && (code <= 4'd6);
  endfunction

  function automatic logic data_code_ok(input logic [3:0] code);
    return (code >= 4'd1) && (code <= 4'd10);
  endfunction

  function automatic ew_e code_width(input logic [3:0] code);
    ew_e w;
    case (code)
      4'd1, 4'd2, 4'd10:      w = EW_8;
      4'd3, 4'd4, 4'd7, 4'd8: w = EW_16;
      default:                w = EW_32;
    endcase
    return w;
  endfunction

endpackage

// File: rtl/pmask_cmd_check.sv
module pmask_cmd_check
  import pmask_fill_pkg::*;
#(
  parameter int NUM_LANES = 128,
  parameter int CNT_W     = 16,
  localparam int LANE_W   = $clog2(NUM_LANES + 1)
) (
  input  logic [7:0]        polarity,
  input  logic [3:0]        pred_type,
  input  logic [3:0]        in_type,
  input  logic [3:0]        out_type,
  input  logic [1:0]        imm_mode,
  input  logic [LANE_W-1:0] lanes,
  input  logic [CNT_W-1:0]  count,
  output logic              legal,
  output ew_e               pred_w,
  output ew_e               data_w
);

  logic pol_ok, types_ok, mode_ok, lanes_ok, count_ok;

  always_comb begin
    pol_ok   = (polarity <= 8'd1);
    types_ok = pred_code_ok(pred_type) && data_code_ok(in_type) && (in_type == out_type);
    mode_ok  = (fill_mode_e'(imm_mode) != FILL_BAD);
    lanes_ok = (lanes != '0) && (lanes <= LANE_W'(NUM_LANES));
    count_ok = (count != '0);
    legal    = pol_ok && types_ok && mode_ok && lanes_ok && count_ok;
    pred_w   = code_width(pred_type);
    data_w   = code_width(out_type);
  end

endmodule

// File: rtl/pmask_lane_ctr.sv
module pmask_lane_ctr #(
  parameter int NUM_LANES = 128,
  parameter int CNT_W     = 16,
  localparam int LANE_W   = $clog2(NUM_LANES + 1),
  localparam int IDX_W    = $clog2(NUM_LANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [CNT_W-1:0]  count,
  input  logic [LANE_W-1:0] lanes,
  input  logic              step,
  output logic [IDX_W-1:0]  lane,
  output logic              last
);

  logic [CNT_W-1:0] rem_q;
  logic [IDX_W-1:0] lane_q;
  logic             wrap;

  assign wrap = (LANE_W'(lane_q) == lanes - LANE_W'(1));
  assign lane = lane_q;
  assign last = (rem_q == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      lane_q <= '0;
    end else if (load) begin
      rem_q  <= count;
      lane_q <= '0;
    end else if (step) begin
      rem_q  <= rem_q - CNT_W'(1);
      lane_q <= wrap ? '0 : lane_q + IDX_W'(1);
    end
  end

  // R9: never consume past the element count
  a_r9_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> rem_q != '0);

  // R6: lane index stays inside the active lane range
  a_r6_lane_bound: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> LANE_W'(lane_q) < lanes);

endmodule

// File: rtl/pmask_merge.sv
module pmask_merge
  import pmask_fill_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              pol,
  input  ew_e               pred_w,
  input  ew_e               data_w,
  input  logic [DATA_W-1:0] pred,
  input  logic [DATA_W-1:0] old_val,
  input  logic [DATA_W-1:0] fill,
  output logic              hit,
  output logic [DATA_W-1:0] result
);

  function automatic logic [DATA_W-1:0] width_mask(input ew_e w);
    logic [DATA_W-1:0] m;
    case (w)
      EW_8:    m = DATA_W'(8'hFF);
      EW_16:   m = DATA_W'(16'hFFFF);
      default: m = '1;
    endcase
    return m;
  endfunction

  logic [DATA_W-1:0] dmask;
  logic              write;

  always_comb begin
    hit    = |(pred & width_mask(pred_w));
    write  = (hit == pol);
    dmask  = width_mask(data_w);
    result = write ? ((old_val & ~dmask) | (fill & dmask)) : old_val;
  end

endmodule

// File: rtl/pmask_fill.sv
module pmask_fill
  import pmask_fill_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int NUM_LANES = 128,
  parameter int CNT_W     = 16,
  localparam int LANE_W   = $clog2(NUM_LANES + 1),
  localparam int IDX_W    = $clog2(NUM_LANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [7:0]        cmd_polarity,
  input  logic [3:0]        cmd_pred_type,
  input  logic [3:0]        cmd_in_type,
  input  logic [3:0]        cmd_out_type,
  input  logic [1:0]        cmd_imm_mode,
  input  logic [DATA_W-1:0] cmd_imm,
  input  logic [LANE_W-1:0] cmd_lanes,
  input  logic [CNT_W-1:0]  cmd_count,
  output logic              cmd_error,
  input  logic              pred_valid,
  output logic              pred_ready,
  input  logic [DATA_W-1:0] pred_data,
  input  logic              dst_in_valid,
  output logic              dst_in_ready,
  input  logic [DATA_W-1:0] dst_in_data,
  output logic              dst_out_valid,
  input  logic              dst_out_ready,
  output logic [DATA_W-1:0] dst_out_data,
  output logic [IDX_W-1:0]  fill_idx,
  input  logic [DATA_W-1:0] fill_data
);

  // command capture
  logic              busy_q, err_q, pol_q;
  ew_e               pred_w_q, data_w_q;
  fill_mode_e        mode_q;
  logic [DATA_W-1:0] imm_q;
  logic [LANE_W-1:0] lanes_q;

  logic              legal;
  ew_e               pred_w_c, data_w_c;
  logic              cmd_fire, take, last;
  logic [IDX_W-1:0]  lane;

  // output register
  logic              out_v_q;
  logic [DATA_W-1:0] out_d_q;
  logic [DATA_W-1:0] fill_val, merged;
  logic              hit;

  pmask_cmd_check #(.NUM_LANES(NUM_LANES), .CNT_W(CNT_W)) u_check (
    .polarity  (cmd_polarity),
    .pred_type (cmd_pred_type),
    .in_type   (cmd_in_type),
    .out_type  (cmd_out_type),
    .imm_mode  (cmd_imm_mode),
    .lanes     (cmd_lanes),
    .count     (cmd_count),
    .legal     (legal),
    .pred_w    (pred_w_c),
    .data_w    (data_w_c)
  );

  assign cmd_ready = !busy_q;
  assign cmd_fire  = cmd_valid && cmd_ready;
  assign take      = busy_q && pred_valid && dst_in_valid && (!out_v_q || dst_out_ready);

  assign pred_ready    = take;
  assign dst_in_ready  = take;
  assign dst_out_valid = out_v_q;
  assign dst_out_data  = out_d_q;
  assign cmd_error     = err_q;

  pmask_lane_ctr #(.NUM_LANES(NUM_LANES), .CNT_W(CNT_W)) u_lane (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (cmd_fire && legal),
    .count (cmd_count),
    .lanes (lanes_q),
    .step  (take),
    .lane  (lane),
    .last  (last)
  );

  always_comb begin
    case (mode_q)
      FILL_LANE:  fill_idx = lane;
      FILL_FIXED: fill_idx = imm_q[IDX_W-1:0];
      default:    fill_idx = '0;
    endcase
    fill_val = (mode_q == FILL_INLINE) ? imm_q : fill_data;
  end

  pmask_merge #(.DATA_W(DATA_W)) u_merge (
    .pol     (pol_q),
    .pred_w  (pred_w_q),
    .data_w  (data_w_q),
    .pred    (pred_data),
    .old_val (dst_in_data),
    .fill    (fill_val),
    .hit     (hit),
    .result  (merged)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      err_q    <= 1'b0;
      pol_q    <= 1'b0;
      pred_w_q <= EW_8;
      data_w_q <= EW_8;
      mode_q   <= FILL_INLINE;
      imm_q    <= '0;
      lanes_q  <= LANE_W'(1);
    end else begin
      err_q <= cmd_fire && !legal;
      if (cmd_fire && legal) begin
        busy_q   <= 1'b1;
        pol_q    <= cmd_polarity[0];
        pred_w_q <= pred_w_c;
        data_w_q <= data_w_c;
        mode_q   <= fill_mode_e'(cmd_imm_mode);
        imm_q    <= cmd_imm;
        lanes_q  <= cmd_lanes;
      end else if (take && last) begin
        busy_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_v_q <= 1'b0;
      out_d_q <= '0;
    end else if (take) begin
      out_v_q <= 1'b1;
      out_d_q <= merged;
    end else if (dst_out_ready) begin
      out_v_q <= 1'b0;
    end
  end

  // R4: a dropped command leaves the unit idle and consumes nothing
  a_r4_drop_idle: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> (cmd_ready && !pred_ready));

  // R8: a stalled output keeps valid and data
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_out_valid && !dst_out_ready) |=> (dst_out_valid && $stable(dst_out_data)));

  // R1/R2: an element that is not filled comes out equal to its old value
  a_r1_keep_old: assert property (@(posedge clk) disable iff (!rst_n)
    (take && (hit != pol_q)) |=> (dst_out_data == $past(dst_in_data)));

  // R9: no element is taken while idle
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !dst_in_ready);

endmodule

// File: tb/pmask_fill_bench.sv
module pmask_fill_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [7:0]  cmd_polarity = '0;
  logic [3:0]  cmd_pred_type = '0, cmd_in_type = '0, cmd_out_type = '0;
  logic [1:0]  cmd_imm_mode = '0;
  logic [31:0] cmd_imm = '0;
  logic [7:0]  cmd_lanes = '0;
  logic [15:0] cmd_count = '0;
  logic        cmd_error;
  logic        pred_valid = 1'b0, pred_ready;
  logic [31:0] pred_data = '0;
  logic        dst_in_valid = 1'b0, dst_in_ready;
  logic [31:0] dst_in_data = '0;
  logic        dst_out_valid, dst_out_ready;
  logic [31:0] dst_out_data;
  logic [6:0]  fill_idx;
  logic [31:0] fill_data;

  int nchecks = 0, nerr = 0, ngot = 0, cyc = 0;
  bit bp_on = 0, finished = 0, stall_pend = 0;
  logic [31:0] stall_data;
  logic [31:0] got [32];
  logic [31:0] pin [32];
  logic [31:0] oin [32];
  logic [31:0] expv [32];

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] tbl(input int i);
    return 32'hA500_0000 + 32'(i) * 32'h0001_0203;
  endfunction

  assign fill_data = tbl(int'(fill_idx));

  pmask_fill u_pmask_fill (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_polarity(cmd_polarity), .cmd_pred_type(cmd_pred_type),
    .cmd_in_type(cmd_in_type), .cmd_out_type(cmd_out_type),
    .cmd_imm_mode(cmd_imm_mode), .cmd_imm(cmd_imm), .cmd_lanes(cmd_lanes),
    .cmd_count(cmd_count), .cmd_error(cmd_error),
    .pred_valid(pred_valid), .pred_ready(pred_ready), .pred_data(pred_data),
    .dst_in_valid(dst_in_valid), .dst_in_ready(dst_in_ready), .dst_in_data(dst_in_data),
    .dst_out_valid(dst_out_valid), .dst_out_ready(dst_out_ready), .dst_out_data(dst_out_data),
    .fill_idx(fill_idx), .fill_data(fill_data)
  );

  // {polarity, pred type, data type, imm, pred, old, expected}
  localparam logic [143:0] VEC [NV] = '{
    {8'd0, 4'd1, 4'd5,  32'hDEADBEEF, 32'h0000_0001, 32'h1111_1111, 32'h1111_1111}, // R1 keep
    {8'd0, 4'd1, 4'd5,  32'hDEADBEEF, 32'h0000_0000, 32'h1111_1111, 32'hDEADBEEF}, // R1 fill
    {8'd1, 4'd1, 4'd5,  32'hDEADBEEF, 32'h0000_0001, 32'h2222_2222, 32'hDEADBEEF}, // R2 fill
    {8'd1, 4'd1, 4'd5,  32'hDEADBEEF, 32'h0000_0000, 32'h2222_2222, 32'h2222_2222}, // R2 keep
    {8'd1, 4'd1, 4'd5,  32'hDEADBEEF, 32'h0000_0100, 32'h3333_3333, 32'h3333_3333}, // R3 u8 high bit ignored
    {8'd1, 4'd3, 4'd5,  32'hDEADBEEF, 32'h0001_0000, 32'h4444_4444, 32'h4444_4444}, // R3 u16 high bit ignored
    {8'd1, 4'd4, 4'd5,  32'hDEADBEEF, 32'h0000_8000, 32'h4444_4444, 32'hDEADBEEF}, // R3 s16 sign bit true
    {8'd1, 4'd6, 4'd5,  32'hDEADBEEF, 32'h8000_0000, 32'h4444_4444, 32'hDEADBEEF}, // R3 s32 sign bit true
    {8'd1, 4'd1, 4'd1,  32'h1234_56AB, 32'h0000_0001, 32'h5555_5555, 32'h5555_55AB}, // R5 8-bit
    {8'd1, 4'd1, 4'd7,  32'hFFFF_7C00, 32'h0000_0001, 32'h6666_6666, 32'h6666_7C00}, // R5 16-bit
    {8'd0, 4'd2, 4'd9,  32'hFF80_0000, 32'h0000_0000, 32'h3F80_0000, 32'hFF80_0000}, // R1 32-bit neg inf
    {8'd0, 4'd5, 4'd2,  32'h0000_0080, 32'h0000_0000, 32'h7777_7777, 32'h7777_7780}  // R5 s8
  };

  task automatic check(input bit c, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchecks++;
    if (!c) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
      $finish;
    end
  endtask

  // output monitor: drives ready, records transfers, checks held outputs (R8)
  always @(negedge clk) begin
    cyc++;
    dst_out_ready = bp_on ? ((cyc % 3) != 0) : 1'b1;
    #1;
    if (stall_pend)
      check(dst_out_valid && dst_out_data == stall_data, "R8 stalled output held", dst_out_data, stall_data);
    stall_pend = dst_out_valid && !dst_out_ready;
    stall_data = dst_out_data;
    if (dst_out_valid && dst_out_ready) begin
      if (ngot < 32) got[ngot] = dst_out_data;
      ngot++;
    end
  end

  task automatic send_cmd(input logic [7:0] pol, input logic [3:0] pt, input logic [3:0] it,
                          input logic [3:0] ot, input logic [1:0] md, input logic [31:0] imm,
                          input logic [7:0] ln, input logic [15:0] cnt);
    @(negedge clk);
    cmd_polarity = pol; cmd_pred_type = pt; cmd_in_type = it; cmd_out_type = ot;
    cmd_imm_mode = md; cmd_imm = imm; cmd_lanes = ln; cmd_count = cnt; cmd_valid = 1'b1;
    #1;
    while (!cmd_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic stream(input int first, input int n);
    for (int i = first; i < first + n; ) begin
      @(negedge clk);
      pred_valid = 1'b1; dst_in_valid = 1'b1;
      pred_data = pin[i]; dst_in_data = oin[i];
      #1;
      if (pred_ready) i++;
    end
    @(negedge clk);
    pred_valid = 1'b0; dst_in_valid = 1'b0;
  endtask

  task automatic wait_out(input int n);
    int t = 0;
    while (ngot < n && t < 300) begin @(negedge clk); #2; t++; end
  endtask

  task automatic illegal(input logic [7:0] pol, input logic [3:0] pt, input logic [3:0] it,
                         input logic [3:0] ot, input logic [1:0] md, input logic [7:0] ln,
                         input logic [15:0] cnt, input string what);
    ngot = 0;
    send_cmd(pol, pt, it, ot, md, 32'h1, ln, cnt);
    check(cmd_error == 1'b1, {"R4 error pulse ", what}, 32'(cmd_error), 32'd1);
    pred_valid = 1'b1; dst_in_valid = 1'b1; pred_data = 32'h0; dst_in_data = 32'h9;
    #1;
    check(pred_ready == 1'b0, {"R4 nothing consumed ", what}, 32'(pred_ready), 32'd0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); #1;
      if (k == 0) check(cmd_error == 1'b0, {"R4 pulse one cycle ", what}, 32'(cmd_error), 32'd0);
      check(pred_ready == 1'b0 && cmd_ready == 1'b1, {"R4 unit stays idle ", what}, 32'(pred_ready), 32'd0);
    end
    pred_valid = 1'b0; dst_in_valid = 1'b0;
    @(negedge clk); #2;
    check(ngot == 0, {"R4 no output ", what}, 32'(ngot), 32'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nchecks++; nerr++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    finish_run();
  end

  initial begin
    // R10 reset state
    repeat (2) @(negedge clk);
    #1;
    check(cmd_ready == 1'b1, "R10 cmd_ready after reset", 32'(cmd_ready), 32'd1);
    check(dst_out_valid == 1'b0, "R10 no output after reset", 32'(dst_out_valid), 32'd0);
    check(cmd_error == 1'b0, "R10 no error after reset", 32'(cmd_error), 32'd0);
    rst_n = 1'b1;

    // table of single-element commands, inline immediate, one lane
    for (int v = 0; v < NV; v++) begin
      ngot = 0;
      pin[0] = VEC[v][95:64]; oin[0] = VEC[v][63:32];
      send_cmd(VEC[v][143:136], VEC[v][135:132], VEC[v][131:128], VEC[v][131:128],
               2'd0, VEC[v][127:96], 8'd1, 16'd1);
      stream(0, 1);
      wait_out(1);
      check(ngot == 1 && got[0] == VEC[v][31:0], $sformatf("R1/R2/R3/R5 vector %0d", v),
            got[0], VEC[v][31:0]);
    end

    // R6 per-lane lookup across 3 lanes under back-pressure, then R7 right behind it
    ngot = 0;
    for (int i = 0; i < 7; i++) begin
      pin[i] = (i % 2 == 0) ? 32'h0000_0001 : 32'h0000_0000;
      oin[i] = 32'h0000_1000 + 32'(i);
      expv[i] = (i % 2 == 0) ? tbl(i % 3) : oin[i];
    end
    for (int i = 7; i < 11; i++) begin
      pin[i] = (i == 8) ? 32'h0000_0100 : 32'h0;   // R3: bit 8 ignored for u8 predicate
      oin[i] = 32'h0000_2000 + 32'(i);
      expv[i] = tbl(8'h45);
    end
    bp_on = 1;
    send_cmd(8'd1, 4'd5, 4'd5, 4'd5, 2'd1, 32'h0, 8'd3, 16'd7);
    #1;
    check(cmd_ready == 1'b0, "R9 busy after legal command", 32'(cmd_ready), 32'd0);
    stream(0, 7);
    check(cmd_ready == 1'b1, "R9 idle after last element", 32'(cmd_ready), 32'd1);
    send_cmd(8'd0, 4'd1, 4'd6, 4'd6, 2'd2, 32'hFFFF_FFC5, 8'd128, 16'd4);
    stream(7, 4);
    wait_out(11);
    bp_on = 0;
    check(ngot == 11, "R8 output count across boundary", 32'(ngot), 32'd11);
    for (int i = 0; i < 11; i++)
      check(got[i] == expv[i], $sformatf("%s element %0d", (i < 7) ? "R6" : "R7", i), got[i], expv[i]);

    // R8 full throughput: four elements back to back
    ngot = 0;
    for (int i = 0; i < 4; i++) begin pin[i] = 32'h1; oin[i] = 32'(i); end
    send_cmd(8'd0, 4'd1, 4'd5, 4'd5, 2'd0, 32'h0, 8'd1, 16'd4);
    begin
      int accepted = 0;
      for (int c = 0; c < 4; c++) begin
        @(negedge clk);
        pred_valid = 1'b1; dst_in_valid = 1'b1; pred_data = pin[accepted]; dst_in_data = oin[accepted];
        #1;
        if (pred_ready) accepted++;
      end
      @(negedge clk); pred_valid = 1'b0; dst_in_valid = 1'b0;
      check(accepted == 4, "R8 one element per cycle", 32'(accepted), 32'd4);
    end
    wait_out(4);
    for (int i = 0; i < 4; i++)
      check(got[i] == 32'(i), "R8 order kept", got[i], 32'(i));

    // R4 illegal commands
    illegal(8'd2, 4'd1, 4'd5, 4'd5, 2'd0, 8'd1, 16'd1, "polarity 2");
    illegal(8'd0, 4'd11, 4'd5, 4'd5, 2'd0, 8'd1, 16'd1, "64-bit predicate");
    illegal(8'd0, 4'd7, 4'd5, 4'd5, 2'd0, 8'd1, 16'd1, "float predicate");
    illegal(8'd0, 4'd1, 4'd5, 4'd6, 2'd0, 8'd1, 16'd1, "type mismatch");
    illegal(8'd0, 4'd1, 4'd12, 4'd12, 2'd0, 8'd1, 16'd1, "64-bit data");
    illegal(8'd0, 4'd1, 4'd5, 4'd5, 2'd3, 8'd1, 16'd1, "fill mode 3");
    illegal(8'd0, 4'd1, 4'd5, 4'd5, 2'd0, 8'd0, 16'd1, "zero lanes");
    illegal(8'd0, 4'd1, 4'd5, 4'd5, 2'd0, 8'd129, 16'd1, "129 lanes");
    illegal(8'd0, 4'd1, 4'd5, 4'd5, 2'd0, 8'd1, 16'd0, "zero count");

    // legal command still works after the drops (R2)
    ngot = 0;
    pin[0] = 32'h1; oin[0] = 32'h0;
    send_cmd(8'd1, 4'd1, 4'd5, 4'd5, 2'd0, 32'hCAFE_F00D, 8'd1, 16'd1);
    stream(0, 1);
    wait_out(1);
    check(ngot == 1 && got[0] == 32'hCAFE_F00D, "R2 fill after dropped commands", got[0], 32'hCAFE_F00D);

    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule